// File: doc/BRIEF.md
# Congestion-aware output path selector

This block picks the next hop for a header flit inside one subnetwork of a mesh router that has diagonal links. The router has already worked out where the destination lies relative to the current node. That relation is coded as one bit saying the destination is further along the subnetwork's horizontal direction, plus a vertical field for north, south or same row. From it the block forms a set of up to three minimal candidate outputs. It then keeps only those whose output link is free. Among those it chooses the one whose downstream neighbour reports the least congestion. A candidate whose link or router is flagged faulty goes to the back of the order.

A mode input sets the policy. In congestion-aware mode the congestion indices decide the choice. In fixed mode they are ignored, and the candidates are tried in the order diagonal, horizontal, vertical. The eastbound and westbound subnetworks use the same selection; the westbound one reports its port codes offset by six.

The result is registered. It appears one clock after the request is sampled. If no candidate is free, the valid output stays low so that the header waits and is offered again.

Top module: `cong_path_sel`

## Requirements
- R1: While rst_n is low and in the first cycle after it, sel_valid is 0 and sel_port is 0.
- R2: Output indices within a subnetwork are 0 local ejection, 1 horizontal, 2 vertical-north, 3 vertical-south, 4 diagonal-north and 5 diagonal-south. dir[2]=1 means the destination lies further along the horizontal direction. dir[1:0]=01 means north, 10 means south, and 00 or 11 mean the same row. Horizontal with north gives the candidates {4,1,2} and horizontal with south gives {5,1,3}. Horizontal alone gives {1}, north alone {2}, south alone {3], and neither gives {0}.
- R3: A candidate is considered only when its bit in avail (bit = output index) is 1.
- R4: With mode=1, the block selects the considered candidate whose congestion field is smallest. The field for index i is cong[i*CONG_W +: CONG_W].
- R5: A candidate whose fault bit (bit = output index) is 1 is chosen only when no considered candidate is healthy. Among faulty candidates the rules of R4, R6 and R7 still apply.
- R6: When congestion fields are equal, the diagonal candidate wins first, then the horizontal, then the vertical.
- R7: With mode=0, congestion fields are ignored. The block picks the first considered healthy candidate in the order diagonal, horizontal, vertical.
- R8: With subnet=1 the selection is the same as with subnet=0, and sel_port is the output index plus 6.
- R9: When a request has no considered candidate, sel_valid is 0 in the next cycle and sel_port keeps its previous value.
- R10: The result of a request sampled at one clock edge appears after that edge. When req_valid is 0, sel_valid is 0 after the edge and sel_port holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A header flit requests a route this cycle |
| subnet | input | 1 | 0 eastbound, 1 westbound |
| dir | input | 3 | Destination relation: bit 2 horizontal ahead, bits 1:0 vertical |
| mode | input | 1 | 1 congestion-aware, 0 fixed order |
| avail | input | 6 | Per-output link free |
| fault | input | 6 | Per-output link or neighbour faulty |
| cong | input | 6*CONG_W | Congestion index reported by each neighbour |
| sel_valid | output | 1 | A route was chosen for the last request |
| sel_port | output | 4 | Chosen port code (index plus 6 for westbound) |

## Verification
Single-candidate directions check the mapping from direction to port. Each is tried with its link free and with it blocked, which separates mapping errors from availability errors. Three-candidate directions use congestion patterns that give a strict minimum in each slot, patterns with equal values, and patterns where a fault sits on the least congested slot. These separate the comparison, the tie order and the fault demotion. The same patterns in fixed mode show that congestion is ignored there, and a westbound copy shows the port offset. A long random run, compared every clock against a behavioural model, covers the mixtures of blocked links, faults and idle cycles that the directed cases leave out.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int NPORT   = 6;
  localparam int NSLOT   = 3;
  localparam int IDX_W   = $clog2(NPORT);
  localparam int PCODE_W = $clog2(2 * NPORT);

  typedef enum logic [IDX_W-1:0] {
    P_LOCAL  = 3'd0,
    P_HORIZ  = 3'd1,
    P_VERT_N = 3'd2,
    P_VERT_S = 3'd3,
    P_DIAG_N = 3'd4,
    P_DIAG_S = 3'd5
  } port_e;

  // slot order doubles as tie priority: diagonal, horizontal, vertical
  localparam int SLOT_DIAG  = 0;
  localparam int SLOT_HORIZ = 1;
  localparam int SLOT_VERT  = 2;
endpackage

// File: rtl/cps_cand_map.sv
module cps_cand_map
  import cps_pkg::*;
(
  input  logic [2:0] dir,
  output logic       slot_vld [NSLOT],
  output port_e      slot_idx [NSLOT]
);
  logic h_ahead, go_n, go_s, at_dest;

  always_comb begin
    h_ahead = dir[2];
    go_n    = (dir[1:0] == 2'b01);
    go_s    = (dir[1:0] == 2'b10);
    at_dest = !h_ahead && !go_n && !go_s;

    slot_vld[SLOT_DIAG]  = h_ahead && (go_n || go_s);
    slot_idx[SLOT_DIAG]  = go_n ? P_DIAG_N : P_DIAG_S;

    // the horizontal slot also carries local ejection
    slot_vld[SLOT_HORIZ] = h_ahead || at_dest;
    slot_idx[SLOT_HORIZ] = at_dest ? P_LOCAL : P_HORIZ;

    slot_vld[SLOT_VERT]  = go_n || go_s;
    slot_idx[SLOT_VERT]  = go_n ? P_VERT_N : P_VERT_S;
  end
endmodule

// File: rtl/cps_key_gen.sv
module cps_key_gen
  import cps_pkg::*;
#(
  parameter int CONG_W = 4,
  localparam int KEY_W = CONG_W + 1
) (
  input  logic                    vld,
  input  port_e                   idx,
  input  logic                    mode,
  input  logic [NPORT-1:0]        avail,
  input  logic [NPORT-1:0]        fault,
  input  logic [NPORT*CONG_W-1:0] cong,
  output logic                    elig,
  output logic [KEY_W-1:0]        key
);
  logic [CONG_W-1:0] cval;

  always_comb begin
    cval = cong[int'(idx)*CONG_W +: CONG_W];
    elig = vld && avail[idx];
    // fault forms the top bit so any faulty slot sorts after every healthy one
    key  = {fault[idx], (mode ? cval : {CONG_W{1'b0}})};
  end
endmodule

// File: rtl/cps_min_pick.sv
module cps_min_pick
  import cps_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic             elig [NSLOT],
  input  logic [KEY_W-1:0] key  [NSLOT],
  input  port_e            idx  [NSLOT],
  output logic             found,
  output port_e            win_idx
);
  logic             ch_v [NSLOT];
  logic [KEY_W-1:0] ch_k [NSLOT];
  port_e            ch_i [NSLOT];

  assign ch_v[0] = elig[0];
  assign ch_k[0] = key[0];
  assign ch_i[0] = idx[0];

  // later slots replace the running best only when strictly smaller
  for (genvar g = 1; g < NSLOT; g++) begin : g_chain
    logic take;
    assign take    = elig[g] && (!ch_v[g-1] || (key[g] < ch_k[g-1]));
    assign ch_v[g] = ch_v[g-1] || elig[g];
    assign ch_k[g] = take ? key[g] : ch_k[g-1];
    assign ch_i[g] = take ? idx[g] : ch_i[g-1];
  end

  assign found   = ch_v[NSLOT-1];
  assign win_idx = ch_i[NSLOT-1];
endmodule

// File: rtl/cong_path_sel.sv
module cong_path_sel
  import cps_pkg::*;
#(
  parameter int CONG_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    subnet,
  input  logic [2:0]              dir,
  input  logic                    mode,
  input  logic [NPORT-1:0]        avail,
  input  logic [NPORT-1:0]        fault,
  input  logic [NPORT*CONG_W-1:0] cong,
  output logic                    sel_valid,
  output logic [PCODE_W-1:0]      sel_port
);
  localparam int KEY_W = CONG_W + 1;

  logic             slot_vld  [NSLOT];
  port_e            slot_idx  [NSLOT];
  logic             slot_elig [NSLOT];
  logic [KEY_W-1:0] slot_key  [NSLOT];
  logic             found;
  port_e            win_idx;

  logic               valid_d, valid_q, port_en;
  logic [PCODE_W-1:0] port_d, port_q;

  cps_cand_map u_map (
    .dir      (dir),
    .slot_vld (slot_vld),
    .slot_idx (slot_idx)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_key
    cps_key_gen #(.CONG_W(CONG_W)) u_key (
      .vld   (slot_vld[s]),
      .idx   (slot_idx[s]),
      .mode  (mode),
      .avail (avail),
      .fault (fault),
      .cong  (cong),
      .elig  (slot_elig[s]),
      .key   (slot_key[s])
    );
  end

  cps_min_pick #(.KEY_W(KEY_W)) u_pick (
    .elig    (slot_elig),
    .key     (slot_key),
    .idx     (slot_idx),
    .found   (found),
    .win_idx (win_idx)
  );

  always_comb begin
    valid_d = req_valid && found;
    port_en = valid_d;
    port_d  = PCODE_W'(win_idx) + (subnet ? PCODE_W'(NPORT) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      port_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (port_en) port_q <= port_d;
    end
  end

  assign sel_valid = valid_q;
  assign sel_port  = port_q;
endmodule

// File: rtl/cong_path_sel_chk.sv
module cong_path_sel_chk
  import cps_pkg::*;
#(
  parameter int CONG_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    subnet,
  input logic [2:0]              dir,
  input logic                    mode,
  input logic [NPORT-1:0]        avail,
  input logic [NPORT-1:0]        fault,
  input logic [NPORT*CONG_W-1:0] cong,
  input logic                    sel_valid,
  input logic [PCODE_W-1:0]      sel_port
);
  logic             r_req, r_sub;
  logic [2:0]       r_dir;
  logic [NPORT-1:0] r_avail;
  logic [2:0]       pidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_req   <= 1'b0;
      r_sub   <= 1'b0;
      r_dir   <= '0;
      r_avail <= '0;
    end else begin
      r_req   <= req_valid;
      r_sub   <= subnet;
      r_dir   <= dir;
      r_avail <= avail;
    end
  end

  assign pidx = r_sub ? 3'(sel_port - PCODE_W'(NPORT)) : sel_port[2:0];

  // R10
  out_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> r_req);

  // R3
  picked_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> r_avail[pidx]);

  // R8
  subnet_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (r_sub ? (sel_port >= PCODE_W'(NPORT) && sel_port < PCODE_W'(2*NPORT))
                         : (sel_port < PCODE_W'(NPORT))));

  // R2
  local_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && r_dir[2] == 1'b0 && r_dir[1:0] != 2'b01 && r_dir[1:0] != 2'b10)
      |-> (pidx == 3'd0));

  // R9
  hold_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> $stable(sel_port));

  // R2
  no_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && r_dir[1:0] == 2'b01) |-> (pidx != 3'd3 && pidx != 3'd5));
endmodule

bind cong_path_sel cong_path_sel_chk #(.CONG_W(CONG_W)) chk_i (.*);

// File: tb/cong_path_sel_tb.sv
module cong_path_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        subnet = 1'b0;
  logic [2:0]  dir = '0;
  logic        mode = 1'b0;
  logic [5:0]  avail = '0;
  logic [5:0]  fault = '0;
  logic [23:0] cong = '0;
  logic        sel_valid;
  logic [3:0]  sel_port;

  int checks = 0;
  int errors = 0;
  bit exp_v  = 0;
  int exp_p  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cong_path_sel #(.CONG_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .subnet(subnet),
    .dir(dir), .mode(mode), .avail(avail), .fault(fault), .cong(cong),
    .sel_valid(sel_valid), .sel_port(sel_port)
  );

  task automatic check(input string tag);
    checks++;
    if (sel_valid !== exp_v || int'(sel_port) != exp_p) begin
      errors++;
      $display("FAIL %s: valid=%0b port=%0d expected valid=%0b port=%0d",
               tag, sel_valid, sel_port, exp_v, exp_p);
    end
  endtask

  // behavioural reference from the requirements
  task automatic model(input bit h, input bit [1:0] vy, input bit md, input bit sb,
                       input bit [5:0] av, input bit [5:0] fl, input bit [23:0] cg,
                       output bit f, output int p);
    int cands[$];
    int best = -1;
    int bestc = 0;
    bit n = (vy == 2'b01);
    bit s = (vy == 2'b10);
    if (h && (n || s)) cands.push_back(n ? 4 : 5);
    if (h) cands.push_back(1);
    if (n || s) cands.push_back(n ? 2 : 3);
    if (!h && !n && !s) cands.push_back(0);
    foreach (cands[k]) begin
      int c = cands[k];
      if (av[c]) begin
        int cost = (fl[c] ? 1000 : 0) + (md ? int'(cg[c*4 +: 4]) : 0);
        if (best < 0 || cost < bestc) begin
          best = c;
          bestc = cost;
        end
      end
    end
    f = (best >= 0);
    p = f ? best + (sb ? 6 : 0) : 0;
  endtask

  task automatic step(input bit rv, input bit [2:0] d, input bit md, input bit sb,
                      input bit [5:0] av, input bit [5:0] fl, input bit [23:0] cg,
                      input string tag);
    bit f;
    int p;
    req_valid = rv; dir = d; mode = md; subnet = sb;
    avail = av; fault = fl; cong = cg;
    model(d[2], d[1:0], md, sb, av, fl, cg, f, p);
    if (rv && f) begin
      exp_v = 1;
      exp_p = p;
    end else begin
      exp_v = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: valid=%0b port=%0d expected valid=%0b port=%0d",
             sel_valid, sel_port, exp_v, exp_p);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // single-candidate mapping
    step(1, 3'b000, 1, 0, 6'h3F, 6'h00, 24'h0, "R2 local");
    step(1, 3'b100, 1, 0, 6'h3F, 6'h00, 24'h0, "R2 horizontal");
    step(1, 3'b001, 1, 0, 6'h3F, 6'h00, 24'h0, "R2 north");
    step(1, 3'b010, 1, 0, 6'h3F, 6'h00, 24'h0, "R2 south");
    step(1, 3'b011, 1, 0, 6'h3F, 6'h00, 24'h0, "R2 code 11 local");
    step(1, 3'b001, 1, 0, 6'b111011, 6'h00, 24'h0, "R3 north blocked");
    step(1, 3'b000, 1, 0, 6'b111110, 6'h00, 24'h0, "R9 local blocked");

    // congestion-aware choice, north-east and south-east
    step(1, 3'b101, 1, 0, 6'h3F, 6'h00, {4'd0,4'd5,4'd0,4'd7,4'd2,4'd0}, "R4 horiz least");
    step(1, 3'b110, 1, 0, 6'h3F, 6'h00, {4'd6,4'd0,4'd1,4'd0,4'd4,4'd0}, "R4 vert-south least");
    step(1, 3'b101, 1, 0, 6'h3F, 6'h00, {4'd0,4'd1,4'd0,4'd7,4'd2,4'd0}, "R4 diag least");
    step(1, 3'b101, 1, 0, 6'b111101, 6'h00, {4'd0,4'd5,4'd0,4'd7,4'd2,4'd0}, "R3 least blocked");
    step(1, 3'b101, 1, 0, 6'h3F, 6'h00, {4'd0,4'd3,4'd0,4'd3,4'd3,4'd0}, "R6 all equal");
    step(1, 3'b101, 1, 0, 6'h3F, 6'h00, {4'd0,4'd5,4'd0,4'd3,4'd3,4'd0}, "R6 horiz over vert");

    // fault demotion
    step(1, 3'b101, 1, 0, 6'h3F, 6'b000010, {4'd0,4'd5,4'd0,4'd7,4'd2,4'd0}, "R5 least faulty");
    step(1, 3'b101, 1, 0, 6'h3F, 6'b010110, {4'd0,4'd5,4'd0,4'd7,4'd2,4'd0}, "R5 all faulty");
    step(1, 3'b101, 1, 0, 6'b111101, 6'b010100, {4'd0,4'd1,4'd0,4'd1,4'd9,4'd0}, "R5 faulty only left");

    // fixed order
    step(1, 3'b101, 0, 0, 6'h3F, 6'h00, {4'd0,4'd9,4'd0,4'd1,4'd1,4'd0}, "R7 diag first");
    step(1, 3'b101, 0, 0, 6'b101111, 6'h00, {4'd0,4'd9,4'd0,4'd1,4'd1,4'd0}, "R7 diag taken");
    step(1, 3'b110, 0, 0, 6'b010111, 6'h00, {4'd0,4'd0,4'd0,4'd0,4'd0,4'd0}, "R7 south diag taken");
    step(1, 3'b101, 0, 0, 6'h3F, 6'b010000, {4'd0,4'd0,4'd0,4'd0,4'd9,4'd0}, "R7 diag faulty");

    // westbound mirror
    step(1, 3'b101, 1, 1, 6'h3F, 6'h00, {4'd0,4'd5,4'd0,4'd7,4'd2,4'd0}, "R8 west horiz");
    step(1, 3'b110, 0, 1, 6'h3F, 6'h00, 24'h0, "R8 west diag-south");

    // nothing free, idle
    step(1, 3'b101, 1, 0, 6'b101001, 6'h00, 24'h0, "R9 none free");
    step(0, 3'b100, 1, 0, 6'h3F, 6'h00, 24'h0, "R10 no request");
    step(1, 3'b100, 1, 0, 6'h3F, 6'h00, 24'h0, "R10 request after idle");

    for (int i = 0; i < 600; i++) begin
      bit md = 1'($urandom);
      step(($urandom % 5) != 0, 3'($urandom), md, 1'($urandom), 6'($urandom),
           (($urandom % 3) == 0) ? 6'($urandom) : 6'h00, 24'($urandom),
           md ? "R4 R5 random" : "R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule